// File: doc/BRIEF.md
# Candidate-State Set Tracker for a Four-State Mealy Machine

This block follows a known, fully specified Mealy machine that it cannot inspect directly. It keeps a one-hot mask of every state the machine might be in. It starts from the full set of four states, because the true starting state is unknown. On each strobed observation, made of the input symbol applied to the machine and, in homing mode, the output symbol the machine produced, the block updates the set in a single clock. Each surviving candidate moves to its successor under that input. In homing mode, a candidate is dropped when the output the table predicts for it disagrees with the observed output. In synchronizing mode the observed output is ignored, and the whole set is simply carried through the next-state function.

The machine's behaviour is supplied through two packed parameters: a next-state table and an output table. The block reports three things. It signals when the set has narrowed to a single state, and gives that state's index. It flags when the set has become empty, which means the observations cannot have come from that machine. It also exposes the raw mask.

Internally, a small control machine with three phases summarises the set. The phases are SEARCH (more than one candidate), LOCKED (exactly one) and EMPTY (none). The transitions are:
- SEARCH to LOCKED, on narrowing to one candidate.
- SEARCH to EMPTY, and LOCKED to EMPTY, on a contradiction.
- LOCKED to LOCKED, when tracking continues.
- EMPTY to EMPTY, which is sticky.
- Any phase back to SEARCH, on restart.

Top module: `fsmtrk_tracker`

## Requirements
- R1: After reset, and one cycle after `restart` is high, `cand_mask` is 4'b1111, `identified` is 0 and `inconsistent` is 0. Mask bit i stands for state i, with A=0, B=1, C=2 and D=3.
- R2: In a cycle where both `obs_valid` and `restart` are low, `cand_mask`, `identified`, `state_id` and `inconsistent` keep their values at the next edge, whatever the other inputs are.
- R3: With `sync_mode`=0 and `obs_valid`=1, the next mask is the set of successors under `obs_in` of those candidates whose table output for `obs_in` equals `obs_out`. Candidates whose output disagrees are removed.
- R4: With `sync_mode`=1 and `obs_valid`=1, the next mask is the set of successors under `obs_in` of all candidates, and `obs_out` has no effect. A non-empty set therefore never becomes empty in this mode.
- R5: `identified` is 1 exactly when `cand_mask` has one bit set. At that time `state_id` is the index of that bit; otherwise `state_id` is 0.
- R6: `inconsistent` is 1 exactly when `cand_mask` is zero. Once set, it stays set until `restart`, in either mode.
- R7: When `restart` and `obs_valid` are both high in the same cycle, the restart wins and the set becomes full.
- R8: The tables are packed by entry k = input*4 + state. The successor of entry k is in `NXT_TBL[2k+1:2k]`, and its output is in `OUT_TBL[k]`.
- R9: Without a restart, the number of candidates never grows. A LOCKED tracker either stays LOCKED or becomes EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Reload the full candidate set |
| obs_valid | input | 1 | Observation strobe |
| obs_in | input | IN_W | Input symbol applied to the observed machine |
| obs_out | input | OUT_W | Output symbol seen from the observed machine |
| sync_mode | input | 1 | 0 = homing (output-filtered), 1 = synchronizing (output ignored) |
| cand_mask | output | N_ST | One-hot set of possible current states |
| identified | output | 1 | Exactly one candidate remains |
| state_id | output | ST_W | Index of the single remaining candidate, else 0 |
| inconsistent | output | 1 | No candidate remains |

## Verification
Every register update becomes visible at the ports on the very next edge. A wrong successor mapping or a wrong output filter therefore shows up as a mask mismatch one cycle after the observation that caused it. A phase register that drifts from the mask shows as `identified` or `inconsistent` disagreeing with the mask's population in the same cycle. A bad index register shows as `state_id` pointing outside the mask. Known homing and synchronizing sequences give exact expected masks. A table with no synchronizing sequence shows whether the set is wrongly collapsed.

// File: rtl/fsmtrk_pkg.sv
package fsmtrk_pkg;

    // Summary of the candidate set held by the tracker
    typedef enum logic [1:0] {
        TRK_SEARCH = 2'd0,   // two or more candidates
        TRK_LOCKED = 2'd1,   // exactly one candidate
        TRK_EMPTY  = 2'd2    // observations contradict the table
    } trk_phase_e;

    typedef enum logic {
        MODE_HOME = 1'b0,    // filter candidates by observed output
        MODE_SYNC = 1'b1     // map every candidate, ignore output
    } trk_mode_e;

endpackage

// File: rtl/fsmtrk_step.sv
module fsmtrk_step #(
    parameter int N_ST  = 4,
    parameter int ST_W  = 2,
    parameter int IN_W  = 1,
    parameter int OUT_W = 1,
    parameter int N_IN  = 1 << IN_W,
    parameter logic [N_IN*N_ST*ST_W-1:0]  NXT_TBL = '0,
    parameter logic [N_IN*N_ST*OUT_W-1:0] OUT_TBL = '0
) (
    input  logic [N_ST-1:0]  cur_mask,
    input  logic [IN_W-1:0]  in_sym,
    input  logic [OUT_W-1:0] out_sym,
    input  logic             ignore_out,
    output logic [N_ST-1:0]  nxt_mask
);

    logic [N_ST-1:0] contrib [N_ST];

    // One mapping slice per source state
    for (genvar s = 0; s < N_ST; s++) begin : g_src
        logic [31:0]      entry;
        logic [ST_W-1:0]  succ;
        logic [OUT_W-1:0] pred;
        logic             keep;

        always_comb begin
            entry = 32'(in_sym) * 32'(N_ST) + 32'(s);
            succ  = NXT_TBL[entry*ST_W +: ST_W];
            pred  = OUT_TBL[entry*OUT_W +: OUT_W];
            keep  = cur_mask[s] && (ignore_out || (pred == out_sym));
        end

        assign contrib[s] = keep ? (N_ST'(1) << succ) : '0;
    end

    always_comb begin
        nxt_mask = '0;
        for (int s = 0; s < N_ST; s++) begin
            nxt_mask = nxt_mask | contrib[s];
        end
    end

endmodule

// File: rtl/fsmtrk_classify.sv
module fsmtrk_classify #(
    parameter int N_ST = 4,
    parameter int ST_W = 2
) (
    input  logic [N_ST-1:0] mask,
    output logic            single,
    output logic            none,
    output logic [ST_W-1:0] idx
);

    localparam int CW = $clog2(N_ST + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        idx = '0;
        for (int i = N_ST - 1; i >= 0; i--) begin
            cnt = cnt + CW'(mask[i]);
            if (mask[i]) begin
                idx = ST_W'(i);
            end
        end
        single = (cnt == CW'(1));
        none   = (cnt == '0);
    end

endmodule

// File: rtl/fsmtrk_tracker.sv
module fsmtrk_tracker
    import fsmtrk_pkg::*;
#(
    parameter int N_ST  = 4,
    parameter int IN_W  = 1,
    parameter int OUT_W = 1,
    parameter int ST_W  = (N_ST > 1) ? $clog2(N_ST) : 1,
    parameter int N_IN  = 1 << IN_W,
    parameter logic [N_IN*N_ST*ST_W-1:0]  NXT_TBL = 16'hC98E,
    parameter logic [N_IN*N_ST*OUT_W-1:0] OUT_TBL = 8'h06
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             obs_valid,
    input  logic [IN_W-1:0]  obs_in,
    input  logic [OUT_W-1:0] obs_out,
    input  logic             sync_mode,
    output logic [N_ST-1:0]  cand_mask,
    output logic             identified,
    output logic [ST_W-1:0]  state_id,
    output logic             inconsistent
);

    localparam logic [N_ST-1:0] FULL_SET   = '1;
    localparam trk_phase_e      FULL_PHASE = (N_ST == 1) ? TRK_LOCKED : TRK_SEARCH;

    trk_phase_e      phase_q, phase_d;
    logic [N_ST-1:0] mask_q, mask_d;
    logic [ST_W-1:0] id_q, id_d;
    logic [N_ST-1:0] step_mask;
    logic            nx_single, nx_none;
    logic [ST_W-1:0] nx_idx;
    trk_mode_e       mode;

    assign mode = trk_mode_e'(sync_mode);

    fsmtrk_step #(
        .N_ST(N_ST), .ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W), .N_IN(N_IN),
        .NXT_TBL(NXT_TBL), .OUT_TBL(OUT_TBL)
    ) u_step (
        .cur_mask  (mask_q),
        .in_sym    (obs_in),
        .out_sym   (obs_out),
        .ignore_out(mode == MODE_SYNC),
        .nxt_mask  (step_mask)
    );

    fsmtrk_classify #(
        .N_ST(N_ST), .ST_W(ST_W)
    ) u_cls (
        .mask  (step_mask),
        .single(nx_single),
        .none  (nx_none),
        .idx   (nx_idx)
    );

    // Next-state logic of the tracker
    always_comb begin
        phase_d = phase_q;
        mask_d  = mask_q;
        id_d    = id_q;
        if (restart) begin
            phase_d = FULL_PHASE;
            mask_d  = FULL_SET;
            id_d    = '0;
        end else if (obs_valid) begin
            mask_d = step_mask;
            id_d   = nx_single ? nx_idx : '0;
            unique case (phase_q)
                TRK_SEARCH: begin
                    if (nx_none)        phase_d = TRK_EMPTY;
                    else if (nx_single) phase_d = TRK_LOCKED;
                    else                phase_d = TRK_SEARCH;
                end
                TRK_LOCKED: phase_d = nx_none ? TRK_EMPTY : TRK_LOCKED;
                TRK_EMPTY:  phase_d = TRK_EMPTY;
                default:    phase_d = TRK_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= FULL_PHASE;
            mask_q  <= FULL_SET;
            id_q    <= '0;
        end else begin
            phase_q <= phase_d;
            mask_q  <= mask_d;
            id_q    <= id_d;
        end
    end

    // Outputs
    always_comb begin
        cand_mask    = mask_q;
        state_id     = id_q;
        identified   = 1'b0;
        inconsistent = 1'b0;
        unique case (phase_q)
            TRK_SEARCH: ;
            TRK_LOCKED: identified   = 1'b1;
            TRK_EMPTY:  inconsistent = 1'b1;
            default:    inconsistent = 1'b1;
        endcase
    end

    AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cand_mask == FULL_SET) && !inconsistent); // R1
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && obs_valid) |=> (cand_mask == FULL_SET)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!obs_valid && !restart) |=> $stable(cand_mask) && $stable(state_id)); // R2
    AST_SYNC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && obs_valid && !restart && !inconsistent) |=> !inconsistent); // R4
    AST_LOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        identified == ($countones(cand_mask) == 1)); // R5
    AST_ID_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        identified |-> cand_mask[state_id]); // R5
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        inconsistent == (cand_mask == '0)); // R6
    AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (inconsistent && !restart) |=> inconsistent); // R6
    AST_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($countones(cand_mask) <= $past($countones(cand_mask)))); // R9
    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (identified && !restart) |=> (identified || inconsistent)); // R9

endmodule

// File: tb/fsmtrk_tracker_test.sv
module fsmtrk_tracker_test;

    localparam int CLK_PERIOD = 10;
    // homing table, synchronizing table, table without synchronizing sequence
    localparam logic [15:0] NT1 = 16'hC98E;
    localparam logic [7:0]  OT1 = 8'h06;
    localparam logic [15:0] NT2 = 16'hF9E4;
    localparam logic [7:0]  OT2 = 8'h89;
    localparam logic [15:0] NT3 = 16'h0DA4;
    localparam logic [7:0]  OT3 = 8'h86;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0, obs_valid = 1'b0, sync_mode = 1'b0;
    logic [0:0] obs_in = '0, obs_out = '0;

    logic [3:0] m1, m2, m3;
    logic       f1, f2, f3, i1, i2, i3;
    logic [1:0] s1, s2, s3;
    logic [3:0] e1, e2, e3;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsmtrk_tracker #(.NXT_TBL(NT1), .OUT_TBL(OT1)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .obs_valid(obs_valid),
        .obs_in(obs_in), .obs_out(obs_out), .sync_mode(sync_mode),
        .cand_mask(m1), .identified(f1), .state_id(s1), .inconsistent(i1));
    fsmtrk_tracker #(.NXT_TBL(NT2), .OUT_TBL(OT2)) uut2 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .obs_valid(obs_valid),
        .obs_in(obs_in), .obs_out(obs_out), .sync_mode(sync_mode),
        .cand_mask(m2), .identified(f2), .state_id(s2), .inconsistent(i2));
    fsmtrk_tracker #(.NXT_TBL(NT3), .OUT_TBL(OT3)) uut3 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .obs_valid(obs_valid),
        .obs_in(obs_in), .obs_out(obs_out), .sync_mode(sync_mode),
        .cand_mask(m3), .identified(f3), .state_id(s3), .inconsistent(i3));

    // Reference set update built from R3, R4 and R8
    function automatic logic [3:0] model(logic [3:0] m, logic in, logic o, logic sy,
                                         logic [15:0] nt, logic [7:0] ot);
        logic [3:0] r = '0;
        for (int s = 0; s < 4; s++) begin
            int k = int'(in) * 4 + s;
            if (m[s] && (sy || ot[k] == o)) r[nt[k*2 +: 2]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [1:0] low_idx(logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return 2'(i);
        return 2'd0;
    endfunction

    task automatic chk_inst(string tag, string who, logic [3:0] e, logic [3:0] m,
                            logic f, logic [1:0] sid, logic inc);
        logic ef = ($countones(e) == 1);
        logic [1:0] es = ef ? low_idx(e) : 2'd0;
        logic ei = (e == 4'd0);
        n_chk++;
        if (m !== e || f !== ef || sid !== es || inc !== ei) begin
            n_fail++;
            $display("FAIL %s %s: mask=%b id=%b sid=%0d inc=%b expected mask=%b id=%b sid=%0d inc=%b",
                     tag, who, m, f, sid, inc, e, ef, es, ei);
        end
    endtask

    task automatic chk_val(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk_inst(tag, "uut",  e1, m1, f1, s1, i1);
        chk_inst(tag, "uut2", e2, m2, f2, s2, i2);
        chk_inst(tag, "uut3", e3, m3, f3, s3, i3);
    endtask

    // Called at a falling edge; checks after the next rising edge
    task automatic step(logic rs, logic v, logic in, logic o, logic sy, string tag);
        restart = rs; obs_valid = v; obs_in = in; obs_out = o; sync_mode = sy;
        if (rs) begin
            e1 = 4'hF; e2 = 4'hF; e3 = 4'hF;
        end else if (v) begin
            e1 = model(e1, in, o, sy, NT1, OT1);
            e2 = model(e2, in, o, sy, NT2, OT2);
            e3 = model(e3, in, o, sy, NT3, OT3);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);   // budget is checked in cycles below
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7351));
        e1 = 4'hF; e2 = 4'hF; e3 = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // Homing: input 0,0 with outputs 0,1 leaves A
        step(0, 1, 0, 0, 0, "R3");
        chk_val("R3 first step", m1, 4'b0100);
        step(0, 1, 0, 1, 0, "R3");
        chk_val("R5 final A", m1, 4'b0001);
        chk_val("R5 id A", {f1, 1'b0, s1}, 4'b1000);

        step(1, 0, 0, 0, 0, "R1 restart");
        step(0, 1, 0, 1, 0, "R3");
        chk_val("R3 outputs 1", m1, 4'b1001);
        step(0, 1, 0, 0, 0, "R3");
        chk_val("R5 final C", {f1, 1'b0, s1}, 4'b1010);

        // Idle cycle with other inputs toggling
        step(0, 0, 1, 1, 1, "R2");
        chk_val("R2 hold", m1, 4'b0100);

        // Contradiction from C: input 1 predicts 0, observe 1
        step(0, 1, 1, 1, 0, "R6");
        chk_val("R6 empty", {i1, 3'b000}, 4'b1000);
        step(0, 1, 0, 0, 1, "R6 sync");
        step(0, 1, 1, 0, 0, "R6 home");
        chk_val("R6 sticky", {i1, 3'b000}, 4'b1000);

        step(1, 1, 0, 0, 0, "R7");
        chk_val("R7 full", m1, 4'b1111);

        // Synchronizing sequence 111 on the second table
        for (int k = 0; k < 3; k++) step(0, 1, 1, 1'($urandom), 1, "R4");
        chk_val("R4 sync to D", m2, 4'b1000);
        chk_val("R4 id D", {f2, 1'b0, s2}, 4'b1011);

        // Third table never collapses under synchronizing mode
        for (int k = 0; k < 24; k++) begin
            step(0, 1, 1'($urandom), 1'($urandom), 1, "R4");
            chk_val("R4 no collapse", 4'($countones(m3)), 4'd3);
        end

        // Locked tracker stays at most one candidate
        step(1, 0, 0, 0, 0, "R1");
        step(0, 1, 0, 0, 0, "R9");
        for (int k = 0; k < 12; k++) begin
            step(0, 1, 1'($urandom), 1'($urandom), 1'($urandom), "R9");
            chk_val("R9 locked", {3'b000, ($countones(m1) > 1)}, 4'b0000);
        end

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            step(($urandom % 16) == 0, ($urandom % 4) != 0, 1'($urandom),
                 1'($urandom), 1'($urandom), "R3/R4/R8 random");
        end

        finish_run();
    end

endmodule